// File: doc/BRIEF.md
# Four-Phase Stepper Coil Sequencer

This block turns a stepper motor by driving its four coils through a repeating set of two-coil-on patterns. A delay built from two nested counts decides when each step happens. An outer count selects how many times the inner count runs, so one step takes outer × inner enabled clock cycles. At each step the block moves one place around a four-entry phase table. The direction input sets which way it moves, and the sequence wraps around with no end. The coil pattern sits on the low four bits of a wider output word, and every bit above those four stays zero. A strobe lasting one clock marks every new pattern, so the logic downstream can count steps without comparing patterns.

An enable input pauses the motor in place. While it is low, the present pattern stays on the coils and the delay counters hold their partial count. Raising it again finishes the step that was interrupted. A change of direction does not restart the table. It only changes which neighbouring entry the next step picks.

Top module: `coil_stepper`

## Requirements
- R1: With `dir` = 0 (forward), successive steps show coil patterns 0x3, 0x9, 0xC, 0x6 on bits [3:0] and then wrap back to 0x3. Bit 0 is the first coil.
- R2: With `dir` = 1 (reverse), successive steps walk the same table backwards: 0x6, 0xC, 0x9, 0x3, and wrap.
- R3: Output bits above bit 3 read zero at all times.
- R4: Two consecutive steps are separated by exactly outer × inner enabled clock cycles. A load of zero counts as 2^DLY_W. The first step after reset comes after the same number of enabled cycles.
- R5: A change of `dir` takes effect at the next step, which moves from the current table position to its neighbour in the new direction.
- R6: While `en` is low, the coil pattern holds and the delay progress freezes. After `en` rises again, only the remaining enabled cycles of the interval elapse before the step.
- R7: A synchronous reset (`rst` high at a clock edge) clears the delay counters and the strobe. It loads the first pattern of the direction selected at that edge: 0x3 for forward, 0x6 for reverse.
- R8: `step_o` is high for exactly the one cycle in which a new pattern first appears. Outside reset, the pattern never changes while `step_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes pattern and delay |
| dir | input | 1 | 0 = forward table order, 1 = reverse |
| outer_dly | input | DLY_W | Outer delay count (0 means 2^DLY_W) |
| inner_dly | input | DLY_W | Inner delay count (0 means 2^DLY_W) |
| coil_o | output | OUT_W | Coil pattern on bits [3:0], zeros above |
| step_o | output | 1 | One-cycle strobe with each new pattern |

## Verification
Forward runs that pass the end of the table show whether the index wraps or stops. A reverse run started from the middle of the table shows the difference between continuing from the current position and restarting from the first entry. Intervals built from unequal outer and inner counts, including 1 × 1 and zero loads, show whether the interval is the product of the two loads, and they expose off-by-one errors in either counter. A run with enable dropped partway through an interval shows whether the delay progress is held or lost.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

   localparam int PHASES = 4;
   localparam int IDX_W  = $clog2(PHASES);

   typedef enum logic {
      DIR_FWD = 1'b0,
      DIR_REV = 1'b1
   } step_dir_e;

   // Two-coil-on pattern for each table position, coil 0 in bit 0.
   function automatic logic [3:0] phase_pattern(input logic [IDX_W-1:0] idx);
      logic [3:0] pat;
      case (idx)
         2'd0:    pat = 4'h3;
         2'd1:    pat = 4'h9;
         2'd2:    pat = 4'hC;
         default: pat = 4'h6;
      endcase
      return pat;
   endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [DLY_W-1:0] outer_i,
   input  logic [DLY_W-1:0] inner_i,
   output logic             expire_o
);

   localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

   generate
      if (DLY_W < 1) begin : g_bad_width
         $error("step_timer: DLY_W must be at least 1");
      end
   endgenerate

   logic [DLY_W-1:0] icnt_q;
   logic [DLY_W-1:0] ocnt_q;
   logic             inner_end;
   logic             outer_end;

   // Counting up and comparing against load-1 makes a zero load span 2^DLY_W.
   assign inner_end = (icnt_q == inner_i - ONE);
   assign outer_end = (ocnt_q == outer_i - ONE);
   assign expire_o  = en && inner_end && outer_end;

   always_ff @(posedge clk) begin
      if (rst) begin
         icnt_q <= '0;
         ocnt_q <= '0;
      end else if (en) begin
         if (inner_end) begin
            icnt_q <= '0;
            ocnt_q <= outer_end ? '0 : ocnt_q + ONE;
         end else begin
            icnt_q <= icnt_q + ONE;
         end
      end
   end

   // R6: a paused timer keeps its partial count
   a_r6_timer_frozen : assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(icnt_q) && $stable(ocnt_q)));

   // R4: every expiry restarts both counts from zero
   a_r4_restart_after_expire : assert property (@(posedge clk) disable iff (rst)
      expire_o |=> (icnt_q == '0 && ocnt_q == '0));

endmodule

// File: rtl/phase_walker.sv
module phase_walker
   import stepper_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             advance_i,
   input  step_dir_e        dir_i,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(PHASES - 1);
   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= (dir_i == DIR_REV) ? LAST : '0;
      end else if (advance_i) begin
         idx_q <= (dir_i == DIR_REV) ? idx_q - STEP : idx_q + STEP;
      end
   end

   assign idx_o = idx_q;

   // R1 / R5: forward steps go to the next entry from the current one
   a_r1_forward_next : assert property (@(posedge clk) disable iff (rst)
      (advance_i && dir_i == DIR_FWD) |=> (idx_q == IDX_W'($past(idx_q) + STEP)));

   // R2 / R5: reverse steps go to the previous entry from the current one
   a_r2_reverse_prev : assert property (@(posedge clk) disable iff (rst)
      (advance_i && dir_i == DIR_REV) |=> (idx_q == IDX_W'($past(idx_q) - STEP)));

   // R6: no advance, no movement
   a_r6_index_holds : assert property (@(posedge clk) disable iff (rst)
      !advance_i |=> $stable(idx_q));

endmodule

// File: rtl/coil_driver.sv
module coil_driver
   import stepper_pkg::*;
#(
   parameter int OUT_W = 8
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [OUT_W-1:0] coil_o
);

   generate
      if (OUT_W < 4) begin : g_bad_width
         $error("coil_driver: OUT_W must be at least 4");
      end
   endgenerate

   assign coil_o[3:0] = phase_pattern(idx_i);

   generate
      if (OUT_W > 4) begin : g_pad
         assign coil_o[OUT_W-1:4] = '0;
      end
   endgenerate

endmodule

// File: rtl/coil_stepper.sv
module coil_stepper
   import stepper_pkg::*;
#(
   parameter int OUT_W = 8,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             dir,
   input  logic [DLY_W-1:0] outer_dly,
   input  logic [DLY_W-1:0] inner_dly,
   output logic [OUT_W-1:0] coil_o,
   output logic             step_o
);

   logic             advance;
   logic [IDX_W-1:0] idx;
   logic             step_q;
   step_dir_e        dir_e;

   assign dir_e = step_dir_e'(dir);

   step_timer #(.DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .outer_i  (outer_dly),
      .inner_i  (inner_dly),
      .expire_o (advance)
   );

   phase_walker u_walker (
      .clk       (clk),
      .rst       (rst),
      .advance_i (advance),
      .dir_i     (dir_e),
      .idx_o     (idx)
   );

   coil_driver #(.OUT_W(OUT_W)) u_coils (
      .idx_i  (idx),
      .coil_o (coil_o)
   );

   // Strobe is registered alongside the index so it lines up with the new pattern.
   always_ff @(posedge clk) begin
      if (rst) step_q <= 1'b0;
      else     step_q <= advance;
   end

   assign step_o = step_q;

   // R8: each advance is announced in the following cycle
   a_r8_strobe_follows_step : assert property (@(posedge clk) disable iff (rst)
      advance |=> step_o);

   // R8 / R6: a strobe can only follow an enabled cycle
   a_r8_strobe_needs_enable : assert property (@(posedge clk) disable iff (rst)
      step_o |-> $past(en));

   // R1 / R2: exactly two coils are energised
   a_r1_two_coils_on : assert property (@(posedge clk) disable iff (rst)
      $countones(coil_o[3:0]) == 2);

endmodule

// File: tb/coil_stepper_test.sv
module coil_stepper_test;

   localparam int OUT_W = 8;
   localparam int DLY_W = 8;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             en  = 1'b0;
   logic             dir = 1'b0;
   logic [DLY_W-1:0] outer_dly = 8'd2;
   logic [DLY_W-1:0] inner_dly = 8'd3;
   logic [OUT_W-1:0] coil_o;
   logic             step_o;

   always #10 clk = ~clk;   // 50 MHz

   coil_stepper #(.OUT_W(OUT_W), .DLY_W(DLY_W)) uut (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .dir       (dir),
      .outer_dly (outer_dly),
      .inner_dly (inner_dly),
      .coil_o    (coil_o),
      .step_o    (step_o)
   );

   typedef struct {
      logic [3:0] pat;
      int         gap;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   tests = 0;
   int   fails = 0;
   int   pos   = 0;
   int   since = 0;
   int   mark  = 0;
   logic [OUT_W-1:0] prev_coil = '0;

   function automatic logic [3:0] pat_of(input int p);
      case (p)
         0:       return 4'h3;
         1:       return 4'h9;
         2:       return 4'hC;
         default: return 4'h6;
      endcase
   endfunction

   // enabled-cycle counter used to measure step intervals
   always @(posedge clk) begin
      if (rst)     since <= 0;
      else if (en) since <= since + 1;
   end

   // monitor: pops expected steps and compares
   always @(negedge clk) begin
      if (rst) begin
         prev_coil = coil_o;
      end else begin
         if (step_o) begin
            if (sb.size() == 0) begin
               tests++; fails++;
               $display("FAIL R8: unexpected strobe, coil=%h expected no step", coil_o);
            end else begin
               exp_t e;
               e = sb.pop_front();
               tests++;
               if (coil_o[3:0] != e.pat) begin
                  fails++;
                  $display("FAIL %s: pattern %h expected %h", e.tag, coil_o[3:0], e.pat);
               end
               if (e.gap != 0) begin
                  tests++;
                  if (since - mark != e.gap) begin
                     fails++;
                     $display("FAIL R4: interval %0d expected %0d (%s)", since - mark, e.gap, e.tag);
                  end
               end
               tests++;
               if (coil_o[OUT_W-1:4] != '0) begin
                  fails++;
                  $display("FAIL R3: upper bits %h expected 0", coil_o[OUT_W-1:4]);
               end
            end
            mark = since;
         end else if (coil_o != prev_coil) begin
            tests++; fails++;
            $display("FAIL R8: pattern changed %h -> %h with no strobe expected stable", prev_coil, coil_o);
         end
         prev_coil = coil_o;
      end
   end

   task automatic apply_reset(input logic d);
      rst = 1'b1; en = 1'b0; dir = d;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst  = 1'b0;
      mark = 0;
      pos  = d ? 3 : 0;
      tests++;
      if (coil_o !== {4'h0, pat_of(pos)} || step_o !== 1'b0) begin
         fails++;
         $display("FAIL R7: after reset coil=%h step=%b expected coil=%h step=0",
                  coil_o, step_o, {4'h0, pat_of(pos)});
      end
   endtask

   task automatic push_steps(input logic d, input int n, input int g, input string tag);
      for (int i = 0; i < n; i++) begin
         pos = d ? (pos + 3) % 4 : (pos + 1) % 4;
         sb.push_back('{pat_of(pos), g, tag});
      end
   endtask

   task automatic run_seg(input logic d, input int n, input int g, input string tag,
                          input bit end_rst);
      dir = d;
      en  = 1'b1;
      push_steps(d, n, g, tag);
      wait (sb.size() == 0);
      if (end_rst) begin
         rst = 1'b1; en = 1'b0;
      end
   endtask

   task automatic timed_seg(input int o, input int inr, input int n, input int g);
      apply_reset(1'b0);
      outer_dly = DLY_W'(o);
      inner_dly = DLY_W'(inr);
      run_seg(1'b0, n, g, "R4", 1'b1);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      // R7: reverse reset value, then forward reset value (R3 checked in R7 compare)
      apply_reset(1'b1);
      apply_reset(1'b0);
      outer_dly = 8'd2; inner_dly = 8'd3;

      // R1: forward walk across the wrap
      run_seg(1'b0, 6, 6, "R1", 1'b0);
      // R2 / R5: reverse from the middle of the table
      run_seg(1'b1, 5, 6, "R5", 1'b0);
      // R5: back to forward from the current position
      run_seg(1'b0, 2, 6, "R5", 1'b1);

      // R4: interval is the product of the two loads
      timed_seg(1, 1, 5, 1);
      timed_seg(4, 1, 3, 4);
      timed_seg(1, 5, 3, 5);
      timed_seg(3, 4, 2, 12);
      timed_seg(1, 0, 1, 256);
      timed_seg(0, 1, 1, 256);

      // R6: enable low mid-interval holds pattern and partial count
      apply_reset(1'b0);
      outer_dly = 8'd2; inner_dly = 8'd3;
      en = 1'b1;
      push_steps(1'b0, 2, 6, "R6");
      repeat (3) @(negedge clk);
      en = 1'b0;
      for (int k = 0; k < 7; k++) begin
         @(negedge clk);
         tests++;
         if (coil_o[3:0] != 4'h3 || step_o != 1'b0) begin
            fails++;
            $display("FAIL R6: paused coil=%h step=%b expected coil=3 step=0", coil_o[3:0], step_o);
         end
      end
      en = 1'b1;
      wait (sb.size() == 0);
      rst = 1'b1; en = 1'b0;
      repeat (3) @(negedge clk);

      tests++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R8: %0d steps missing expected 0", sb.size());
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule